// File: doc/BRIEF.md
# Packed BCD Byte Arithmetic Unit

This unit performs decimal arithmetic on packed-BCD bytes, each byte holding two decimal digits. One operation is issued per cycle with a start pulse. Three operations are available: add with extend, subtract with extend, and negate with extend. The incoming extend bit acts as the carry-in or borrow-in, which lets a multi-byte decimal number be processed one byte at a time, least significant byte first.

The arithmetic uses no per-digit compare-and-adjust. Each digit is biased by six before a single binary addition. The carries out of each digit are then recovered by exclusive-OR, and the bias is removed again from every digit that did not carry. Subtraction reuses the same path, with the source in nines-complement form. The result, the carry flag and the extend flag are registered one cycle after start, together with a one-cycle done strobe. The zero flag is sticky: an operation can clear it but can never set it, so a chain of byte operations leaves Z set only when every byte was zero.

A small combinational opcode matcher sits beside the datapath. It recognises the register and memory forms of the three instructions in a 16-bit instruction word and extracts the register numbers.

Top module: `bcd_alu_unit`

## Requirements
- R1: With `op` = 2'b00 and valid BCD operands, `result` equals (dst + src + x_in) mod 100 in decimal, and `c_out` is 1 exactly when that decimal sum is 100 or more.
- R2: With `op` = 2'b01, `result` equals (dst − src − x_in) mod 100 in decimal, and `c_out` is 1 exactly when that difference is negative (a borrow).
- R3: With `op[1]` = 1 (2'b10 is the negate code; 2'b11 acts the same), the operation is 0 − src − x_in in decimal, and the value on `opnd_dst` has no effect on any output.
- R4: After every operation, `x_out` equals `c_out`.
- R5: After every operation, `z_out` equals `z_in` AND (result byte == 0). Z is therefore never set by an operation.
- R6: `result`, the flags and `done` update on the clock edge that samples `start` = 1. `done` is high for exactly that one following cycle. Without `start`, `result` and the flags hold their values.
- R7: A synchronous reset drives `result`, `c_out`, `x_out`, `z_out` and `done` to 0.
- R8: The matcher reports decimal add for (insn & 16'hF1F8) equal to 16'hC100 (register form) or 16'hC108 (memory form), and decimal subtract for 16'h8100 or 16'h8108. In both, `dec_mem` is insn[3], `dec_src` is insn[2:0] and `dec_dst` is insn[11:9].
- R9: The matcher reports negate (`dec_op` = 2'b10) for (insn & 16'hFFC0) == 16'h4800. `dec_src` and `dec_dst` both carry insn[2:0], and `dec_mem` is 1 when insn[5:3] is nonzero.
- R10: Any other instruction word gives `dec_hit` = 0, with the other matcher outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue one operation this cycle |
| op | input | 2 | 00 add, 01 subtract, 1x negate |
| opnd_dst | input | 8 | Destination operand, two BCD digits |
| opnd_src | input | 8 | Source operand, two BCD digits |
| x_in | input | 1 | Incoming extend (carry or borrow in) |
| z_in | input | 1 | Current zero flag |
| result | output | 8 | Registered BCD result |
| c_out | output | 1 | Carry or borrow out |
| x_out | output | 1 | Extend out, equal to carry |
| z_out | output | 1 | Sticky zero flag |
| done | output | 1 | One-cycle result strobe |
| insn | input | 16 | Instruction word for the matcher |
| dec_hit | output | 1 | Instruction word is one of the three forms |
| dec_op | output | 2 | Matched operation, same code as `op` |
| dec_mem | output | 1 | Memory form |
| dec_src | output | 3 | Source register number |
| dec_dst | output | 3 | Destination register number |

## Verification
The unit holds only one stage of state: the result and flag register. A wrong value there shows at the ports on the cycle right after the start pulse that loads it, and it stays visible until the next start. A fault in the digit correction shows as a non-decimal digit or a wrong carry in that same cycle, so the bench compares every output on every clock against a digit-wise decimal model. The sweep covers all operand pairs with both extend values, which puts the digit wrap points (9 to 0, 99 to 00, 00 minus 1) under each operation. A bad zero-flag path is caught because `z_in` varies across the sweep, so a Z that sets where it should hold, or holds where it should clear, appears in the cycle after the operation.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    typedef enum logic [1:0] {
        BOP_ADD = 2'b00,
        BOP_SUB = 2'b01,
        BOP_NEG = 2'b10
    } bcd_op_e;

    // true when every one of the low 'digits' nibbles is 0..9
    function automatic logic is_bcd(input logic [31:0] v, input int digits);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (k < digits && v[4*k +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/bcd_biased_adder.sv
module bcd_biased_adder #(
    parameter int DIGITS = 2
) (
    input  logic [4*DIGITS-1:0] dst,
    input  logic [4*DIGITS-1:0] src,
    input  logic                x_in,
    input  logic                sub,
    output logic [4*DIGITS-1:0] sum,
    output logic                carry
);
    localparam int DW = 4 * DIGITS;
    localparam int W  = DW + 2;
    localparam logic [W-1:0] ALL_ONES = W'((1 << (DW + 1)) - 1);

    logic [W-1:0] bias_w;
    logic [W-1:0] dst_w;
    logic [W-1:0] src_w;
    logic [W-1:0] pre_w;
    logic [W-1:0] tot_w;
    logic [W-1:0] cx_w;
    logic [W-1:0] corr_w;
    logic [W-1:0] fixed_w;

    // a six in every digit position
    generate
        for (genvar k = 0; k < DIGITS; k++) begin : g_bias
            assign bias_w[4*k +: 4] = 4'h6;
        end
    endgenerate
    assign bias_w[W-1:DW] = '0;

    assign dst_w = W'(dst);
    assign src_w = W'(src);

    always_comb begin
        if (sub) begin
            pre_w = ALL_ONES - src_w;
            tot_w = pre_w + dst_w + W'(1) - W'(x_in);
        end else begin
            pre_w = src_w + bias_w;
            tot_w = pre_w + dst_w + W'(x_in);
        end
        cx_w = pre_w ^ dst_w ^ tot_w;
    end

    // the digit that did not carry out gives back its six
    generate
        for (genvar k = 0; k < DIGITS; k++) begin : g_corr
            assign corr_w[4*k +: 4] = cx_w[4*k+4] ? 4'h0 : 4'h6;
        end
    endgenerate
    assign corr_w[W-1:DW] = '0;

    assign fixed_w = tot_w - corr_w;
    assign sum     = fixed_w[DW-1:0];
    assign carry   = fixed_w[DW];

    // R2: equal operands with no borrow in give zero and no borrow out
    always_comb begin
        if (!$isunknown({dst, src, x_in, sub}) && sub && (dst == src) && !x_in) begin
            self_sub_zero_chk: assert (sum == '0 && !carry);
        end
    end

endmodule

// File: rtl/bcd_opcode_match.sv
module bcd_opcode_match (
    input  logic [15:0] insn,
    output logic        hit,
    output logic [1:0]  op,
    output logic        mem,
    output logic [2:0]  src_reg,
    output logic [2:0]  dst_reg
);
    import bcd_pkg::*;

    localparam logic [15:0] PAIR_MASK = 16'hF1F8;
    localparam logic [15:0] NEG_MASK  = 16'hFFC0;

    logic [4:0] m_v;

    assign m_v[0] = (insn & PAIR_MASK) == 16'hC100;
    assign m_v[1] = (insn & PAIR_MASK) == 16'hC108;
    assign m_v[2] = (insn & PAIR_MASK) == 16'h8100;
    assign m_v[3] = (insn & PAIR_MASK) == 16'h8108;
    assign m_v[4] = (insn & NEG_MASK)  == 16'h4800;

    always_comb begin
        hit     = 1'b0;
        op      = 2'b00;
        mem     = 1'b0;
        src_reg = 3'd0;
        dst_reg = 3'd0;
        if (m_v[0] || m_v[1] || m_v[2] || m_v[3]) begin
            hit     = 1'b1;
            op      = (m_v[2] || m_v[3]) ? BOP_SUB : BOP_ADD;
            mem     = insn[3];
            src_reg = insn[2:0];
            dst_reg = insn[11:9];
        end else if (m_v[4]) begin
            hit     = 1'b1;
            op      = BOP_NEG;
            mem     = insn[5:3] != 3'b000;
            src_reg = insn[2:0];
            dst_reg = insn[2:0];
        end
    end

    // R10: the five patterns never overlap
    always_comb begin
        if (!$isunknown(insn)) begin
            single_match_chk: assert ($onehot0(m_v));
        end
    end

endmodule

// File: rtl/bcd_alu_unit.sv
module bcd_alu_unit #(
    parameter int DIGITS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          op,
    input  logic [4*DIGITS-1:0] opnd_dst,
    input  logic [4*DIGITS-1:0] opnd_src,
    input  logic                x_in,
    input  logic                z_in,
    output logic [4*DIGITS-1:0] result,
    output logic                c_out,
    output logic                x_out,
    output logic                z_out,
    output logic                done,
    input  logic [15:0]         insn,
    output logic                dec_hit,
    output logic [1:0]          dec_op,
    output logic                dec_mem,
    output logic [2:0]          dec_src,
    output logic [2:0]          dec_dst
);
    import bcd_pkg::*;

    localparam int DW = 4 * DIGITS;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          c;
        logic          x;
        logic          z;
        logic          done;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic          is_sub;
    logic [DW-1:0] dst_eff;
    logic [DW-1:0] core_sum;
    logic          core_carry;

    assign is_sub  = op[0] || op[1];
    assign dst_eff = op[1] ? '0 : opnd_dst;

    bcd_biased_adder #(.DIGITS(DIGITS)) u_core (
        .dst   (dst_eff),
        .src   (opnd_src),
        .x_in  (x_in),
        .sub   (is_sub),
        .sum   (core_sum),
        .carry (core_carry)
    );

    bcd_opcode_match u_match (
        .insn    (insn),
        .hit     (dec_hit),
        .op      (dec_op),
        .mem     (dec_mem),
        .src_reg (dec_src),
        .dst_reg (dec_dst)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.res  = core_sum;
            st_d.c    = core_carry;
            st_d.x    = core_carry;
            st_d.z    = z_in && (core_sum == '0);
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result = st_q.res;
    assign c_out  = st_q.c;
    assign x_out  = st_q.x;
    assign z_out  = st_q.z;
    assign done   = st_q.done;

    // R1
    bcd_digits_chk: assert property (@(posedge clk) disable iff (rst)
        start && is_bcd(32'(opnd_dst), DIGITS) && is_bcd(32'(opnd_src), DIGITS)
        |=> is_bcd(32'(result), DIGITS));

    // R4
    extend_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (x_out == c_out));

    // R5
    zero_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        start && !z_in |=> !z_out);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done && $stable(result) && $stable(c_out) && $stable(z_out));

endmodule

// File: tb/bcd_alu_unit_bench.sv
module bcd_alu_unit_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [1:0] op;
    logic [7:0] opnd_dst, opnd_src;
    logic       x_in, z_in;
    logic [7:0] result;
    logic       c_out, x_out, z_out, done;
    logic [15:0] insn;
    logic       dec_hit, dec_mem;
    logic [1:0] dec_op;
    logic [2:0] dec_src, dec_dst;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // expectation for the cycle after the last drive
    bit         e_valid = 0;
    string      e_tag;
    int         e_res, e_c, e_z, e_done;

    always #2 clk = ~clk;

    bcd_alu_unit u_bcd_alu_unit (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .opnd_dst(opnd_dst), .opnd_src(opnd_src), .x_in(x_in), .z_in(z_in),
        .result(result), .c_out(c_out), .x_out(x_out), .z_out(z_out), .done(done),
        .insn(insn), .dec_hit(dec_hit), .dec_op(dec_op), .dec_mem(dec_mem),
        .dec_src(dec_src), .dec_dst(dec_dst)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int to_dec(input logic [7:0] b);
        return 10 * int'(b[7:4]) + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic compare_prev();
        if (e_valid) begin
            chk(done == e_done[0], e_tag, "done", done, e_done);
            chk(result == 8'(e_res), e_tag, "result", result, e_res);
            chk(c_out == e_c[0], e_tag, "carry", c_out, e_c);
            chk(x_out == e_c[0], "R4", "extend", x_out, e_c);
            chk(z_out == e_z[0], "R5", "zero", z_out, e_z);
        end
    endtask

    // one cycle: check previous, drive new, model the outcome
    task automatic step(input bit st, input logic [1:0] o, input logic [7:0] d,
                        input logic [7:0] s, input bit x, input bit z);
        int v;
        @(negedge clk);
        compare_prev();
        start = st; op = o; opnd_dst = d; opnd_src = s; x_in = x; z_in = z;
        e_valid = 1;
        e_done  = st ? 1 : 0;
        if (!st) begin
            e_tag = "R6";
        end else begin
            if (o == 2'b00) begin
                e_tag = "R1";
                v = to_dec(d) + to_dec(s) + int'(x);
                e_c = (v >= 100) ? 1 : 0;
                e_res = int'(to_bcd(v % 100));
            end else begin
                e_tag = o[1] ? "R3" : "R2";
                v = (o[1] ? 0 : to_dec(d)) - to_dec(s) - int'(x);
                e_c = (v < 0) ? 1 : 0;
                e_res = int'(to_bcd((v + 100) % 100));
            end
            e_z = (z && e_res == 0) ? 1 : 0;
        end
    endtask

    task automatic dec_check(input logic [15:0] w, input bit hit, input int o,
                             input bit mem, input int s, input int d, input string tag);
        @(negedge clk);
        insn = w;
        #1;
        chk(dec_hit == hit, tag, "dec_hit", dec_hit, hit);
        chk(dec_op == 2'(o), tag, "dec_op", dec_op, o);
        chk(dec_mem == mem, tag, "dec_mem", dec_mem, mem);
        chk(dec_src == 3'(s), tag, "dec_src", dec_src, s);
        chk(dec_dst == 3'(d), tag, "dec_dst", dec_dst, d);
    endtask

    initial begin
        rst = 1; start = 0; op = 0; opnd_dst = 0; opnd_src = 0;
        x_in = 0; z_in = 0; insn = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        chk(result == 8'h00 && !c_out && !x_out && !z_out && !done, "R7",
            "reset state", {result, c_out, x_out, z_out, done}, 0);
        // seed flags nonzero, then reset again
        rst = 0;
        step(1, 2'b00, 8'h99, 8'h99, 1, 1);
        @(negedge clk);
        e_valid = 0;
        rst = 1;
        start = 0;
        @(negedge clk);
        rst = 0;
        chk(result == 8'h00 && !c_out && !x_out && !z_out && !done, "R7",
            "reset clears", {result, c_out, x_out, z_out, done}, 0);

        // R1, R2: full sweep of valid operands, both extend values
        for (int o = 0; o < 2; o++)
            for (int i = 0; i < 100; i++)
                for (int j = 0; j < 100; j++)
                    for (int x = 0; x < 2; x++)
                        step(1, 2'(o), to_bcd(i), to_bcd(j), x[0], ((i + j + x) % 3) != 0);

        // R3: negate, destination operand varied and ignored; both codes
        for (int j = 0; j < 100; j++)
            for (int x = 0; x < 2; x++)
                step(1, (j % 2 == 0) ? 2'b10 : 2'b11, to_bcd((j * 37 + 11) % 100),
                     to_bcd(j), x[0], 1);

        // R6: idle cycles hold, then a strobe, then idle
        step(1, 2'b00, 8'h45, 8'h54, 1, 1);
        step(0, 2'b01, 8'h12, 8'h34, 0, 1);
        step(0, 2'b00, 8'h00, 8'h00, 0, 1);
        // R5: zero kept when set and result zero, never set from clear
        step(1, 2'b00, 8'h50, 8'h50, 0, 1);
        step(1, 2'b01, 8'h27, 8'h27, 0, 0);
        step(1, 2'b01, 8'h27, 8'h27, 0, 1);
        step(0, 2'b00, 8'h00, 8'h00, 0, 0);
        @(negedge clk);
        compare_prev();
        e_valid = 0;

        // R8
        dec_check(16'hC100 | (16'd3 << 9) | 16'd5, 1, 0, 0, 5, 3, "R8");
        dec_check(16'hC108 | (16'd6 << 9) | 16'd2, 1, 0, 1, 2, 6, "R8");
        dec_check(16'h8100 | (16'd7 << 9) | 16'd1, 1, 1, 0, 1, 7, "R8");
        dec_check(16'h810F, 1, 1, 1, 7, 0, "R8");
        // R9
        dec_check(16'h4804, 1, 2, 0, 4, 4, "R9");
        dec_check(16'h4818, 1, 2, 1, 0, 0, "R9");
        // R10
        dec_check(16'hC140, 0, 0, 0, 0, 0, "R10");
        dec_check(16'h4840, 0, 0, 0, 0, 0, "R10");
        dec_check(16'hD100, 0, 0, 0, 0, 0, "R10");
        dec_check(16'h8180, 0, 0, 0, 0, 0, "R10");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule